// File: doc/BRIEF.md
# Address-Filtered Serial Frame Receiver

This block turns a serial bit stream into framed packets. Bits arrive one per accepted strobe, least-significant bit first within each byte. A frame has a fixed layout. The destination address comes first, then the sender's address, then a payload length from 0 to 255. That many payload bytes follow, and one error-check byte closes the frame. The receiver takes a frame when the destination equals the station address on `station_addr` or the broadcast value 0xFF. It writes the payload bytes into an external 256-byte buffer through a write port with an active-low enable.

A frame addressed to another station is still parsed, so that its end can be found. None of its payload is written, and it is reported as ignored. The `carrier` input marks line activity. If it falls part-way through a frame, the frame is reported as bad and the receiver waits for a new destination byte. Each frame ends with a one-cycle status pulse. The pulse carries exactly one of the flags good, bad or ignored, together with the sender address and the length.

The bit input is a valid/ready stream. A bit is consumed in a cycle in which `bit_valid`, `bit_ready` and `carrier` are all high. `bit_ready` is low only in the cycle of the status pulse. A bit offered in that cycle is not consumed, and the source must either hold it or drop it. The buffer write port and the status outputs cannot be back-pressured.

Top module: `pkt_rx_filter`

## Requirements
- R1: After reset, `st_valid` is 0, `buf_we_n` is 1 and `bit_ready` is 1.
- R2: A bit is consumed only when `bit_valid`, `bit_ready` and `carrier` are all high. The first bit consumed in a byte is bit 0 of that byte and the eighth is bit 7. Bits offered while `carrier` is low have no effect on the next frame.
- R3: A frame is destination byte, source byte, length byte, then length payload bytes, then one check byte. The status pulse that ends the frame reports the source byte on `st_src` and the length byte on `st_len`.
- R4: If the destination equals `station_addr` or 0xFF, payload byte k (k counting from 0) is written to buffer address k. `buf_we_n` is low for exactly one cycle, the cycle after the last bit of that byte is consumed.
- R5: If the destination matches neither the station address nor 0xFF, no buffer write occurs and the status pulse has `st_ignored` set.
- R6: The check value is a CRC-8 with polynomial 0x07 and initial value 0x00, shifted most-significant bit first. It runs over the byte values of the destination, source, length and payload bytes. For an accepted frame, `st_good` is set when the check byte equals this value, and `st_bad` is set when it does not.
- R7: If `carrier` is low in a cycle after at least one bit of a frame has been consumed, and before that frame's status pulse, then the next cycle carries a status pulse with `st_bad` set. The receiver then waits for a new destination byte.
- R8: The status pulse `st_valid` lasts one cycle and comes in the cycle after the last bit of the check byte is consumed. During the pulse exactly one of `st_good`, `st_bad` and `st_ignored` is high, and `bit_ready` is low.
- R9: With length 0, the byte that follows the length byte is the check byte, and no buffer write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 8 | This station's address |
| carrier | input | 1 | Line activity indicator |
| bit_valid | input | 1 | Serial bit offered |
| bit_data | input | 1 | Serial bit value |
| bit_ready | output | 1 | Receiver can consume a bit |
| buf_we_n | output | 1 | Buffer write enable, active low |
| buf_addr | output | 8 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| st_valid | output | 1 | One-cycle frame status strobe |
| st_good | output | 1 | Accepted frame with matching check byte |
| st_bad | output | 1 | Check mismatch or carrier loss |
| st_ignored | output | 1 | Frame addressed elsewhere |
| st_src | output | 8 | Source address of the frame |
| st_len | output | 8 | Length byte of the frame |

## Verification
Every result appears one register stage after the bit that causes it. The buffer write for a payload byte and the status pulse after a check byte both land in the cycle after that byte's eighth bit is consumed. A status pulse caused by carrier loss lands in the cycle after the first low-carrier cycle. The bench drives inputs on falling edges and records writes and status on falling edges. It checks `bit_ready` and `st_valid` at the falling edge right after the check byte's final rising edge. Every other result is compared with values the bench computes once the frame has ended.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_DST,
    PH_SRC,
    PH_LEN,
    PH_PAY,
    PH_CHK,
    PH_DONE
  } phase_t;

  function automatic logic [BYTE_W-1:0] crc_step(
    input logic [BYTE_W-1:0] crc_in,
    input logic [BYTE_W-1:0] din,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] c;
    c = crc_in ^ din;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/pkt_rx_deser.sv
module pkt_rx_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic         bit_in,
  output logic         byte_stb,
  output logic [W-1:0] byte_val
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (take) begin
      sh  <= {bit_in, sh[W-1:1]};
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign byte_stb = take && (cnt == LAST);
  assign byte_val = {bit_in, sh[W-1:1]};
endmodule

// File: rtl/pkt_rx_crc.sv
module pkt_rx_crc
  import pkt_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h07,
  parameter logic [BYTE_W-1:0] INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= INIT;
    else if (upd)      crc <= crc_step(crc, din, POLY);
  end
endmodule

// File: rtl/pkt_rx_ctl.sv
module pkt_rx_ctl
  import pkt_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BCAST = 8'hFF,
  parameter int                AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier,
  input  logic              take,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic [BYTE_W-1:0] crc_val,
  output logic              busy,
  output logic              ready,
  output logic              crc_upd,
  output logic              buf_we_n,
  output logic [AW-1:0]     buf_addr,
  output logic [BYTE_W-1:0] buf_wdata,
  output logic              st_valid,
  output logic              st_good,
  output logic              st_bad,
  output logic              st_ignored,
  output logic [BYTE_W-1:0] st_src,
  output logic [BYTE_W-1:0] st_len
);
  phase_t            phase;
  logic              drop;
  logic [BYTE_W-1:0] remain;
  logic [AW-1:0]     idx;

  assign ready   = (phase != PH_DONE);
  assign crc_upd = byte_stb && (phase != PH_CHK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_DST;
      busy       <= 1'b0;
      drop       <= 1'b0;
      remain     <= '0;
      idx        <= '0;
      buf_we_n   <= 1'b1;
      buf_addr   <= '0;
      buf_wdata  <= '0;
      st_valid   <= 1'b0;
      st_good    <= 1'b0;
      st_bad     <= 1'b0;
      st_ignored <= 1'b0;
      st_src     <= '0;
      st_len     <= '0;
    end else begin
      buf_we_n   <= 1'b1;
      st_valid   <= 1'b0;
      st_good    <= 1'b0;
      st_bad     <= 1'b0;
      st_ignored <= 1'b0;
      if (phase == PH_DONE) begin
        phase <= PH_DST;
      end else if (busy && !carrier) begin
        st_valid <= 1'b1;
        st_bad   <= 1'b1;
        busy     <= 1'b0;
        phase    <= PH_DONE;
      end else begin
        if (take) busy <= 1'b1;
        if (byte_stb) begin
          unique case (phase)
            PH_DST: begin
              drop  <= !((byte_val == station_addr) || (byte_val == BCAST));
              phase <= PH_SRC;
            end
            PH_SRC: begin
              st_src <= byte_val;
              phase  <= PH_LEN;
            end
            PH_LEN: begin
              st_len <= byte_val;
              remain <= byte_val;
              idx    <= '0;
              phase  <= (byte_val == '0) ? PH_CHK : PH_PAY;
            end
            PH_PAY: begin
              if (!drop) begin
                buf_we_n  <= 1'b0;
                buf_addr  <= idx;
                buf_wdata <= byte_val;
              end
              idx    <= idx + 1'b1;
              remain <= remain - 1'b1;
              if (remain == 8'd1) phase <= PH_CHK;
            end
            PH_CHK: begin
              st_valid   <= 1'b1;
              st_ignored <= drop;
              st_good    <= !drop && (byte_val == crc_val);
              st_bad     <= !drop && (byte_val != crc_val);
              busy       <= 1'b0;
              phase      <= PH_DONE;
            end
            default: phase <= PH_DST;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF,
  parameter logic [BYTE_W-1:0] CRC_POLY   = 8'h07,
  parameter logic [BYTE_W-1:0] CRC_INIT   = 8'h00,
  parameter int                BUF_AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic              carrier,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              buf_we_n,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [BYTE_W-1:0] buf_wdata,
  output logic              st_valid,
  output logic              st_good,
  output logic              st_bad,
  output logic              st_ignored,
  output logic [BYTE_W-1:0] st_src,
  output logic [BYTE_W-1:0] st_len
);
  logic              take;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  logic [BYTE_W-1:0] crc_val;
  logic              crc_upd;
  logic              busy;

  assign take = bit_valid && bit_ready && carrier;

  pkt_rx_deser #(.W(BYTE_W)) deser_i (
    .clk(clk), .rst_n(rst_n), .clr(!carrier), .take(take), .bit_in(bit_data),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  pkt_rx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk(clk), .rst_n(rst_n), .clr(!busy), .upd(crc_upd), .din(byte_val), .crc(crc_val)
  );

  pkt_rx_ctl #(.BCAST(BCAST_ADDR), .AW(BUF_AW)) ctl_i (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .take(take),
    .byte_stb(byte_stb), .byte_val(byte_val), .station_addr(station_addr),
    .crc_val(crc_val), .busy(busy), .ready(bit_ready), .crc_upd(crc_upd),
    .buf_we_n(buf_we_n), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .st_valid(st_valid), .st_good(st_good), .st_bad(st_bad),
    .st_ignored(st_ignored), .st_src(st_src), .st_len(st_len)
  );
endmodule

// File: rtl/pkt_rx_filter_chk.sv
module pkt_rx_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_ready,
  input logic buf_we_n,
  input logic st_valid,
  input logic st_good,
  input logic st_bad,
  input logic st_ignored
);
  // R8: the status strobe never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  // R8: exactly one outcome flag during the strobe
  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> ($countones({st_good, st_bad, st_ignored}) == 1));

  // R8: no bit is consumed during the strobe
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !bit_ready);

  // R4: a write pulse lasts one cycle
  a_r4_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_we_n |=> buf_we_n);

  // R4: payload writes never coincide with a status strobe
  a_r4_no_write_at_status: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_we_n |-> !st_valid);
endmodule

bind pkt_rx_filter pkt_rx_filter_chk chk_i (.*);

// File: tb/pkt_rx_filter_tb.sv
`timescale 1ns/1ps
module pkt_rx_filter_tb_top;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, carrier, bit_valid, bit_data;
  logic       bit_ready, buf_we_n, st_valid, st_good, st_bad, st_ignored;
  logic [7:0] buf_addr, buf_wdata, st_src, st_len;
  logic [7:0] station_addr;

  pkt_rx_filter dut_i (
    .clk(clk), .rst_n(rst_n), .station_addr(station_addr), .carrier(carrier),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .buf_we_n(buf_we_n), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .st_valid(st_valid), .st_good(st_good), .st_bad(st_bad),
    .st_ignored(st_ignored), .st_src(st_src), .st_len(st_len)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] frm [0:259];
  logic [7:0] seen [0:255];
  int wr_cnt, st_cnt, cap_kind;
  logic [7:0] cap_src, cap_len;

  // records writes and status away from the active edge
  always @(negedge clk) begin
    if (rst_n && !buf_we_n) begin
      seen[buf_addr] = buf_wdata;
      wr_cnt++;
    end
    if (rst_n && st_valid) begin
      st_cnt++;
      cap_kind = st_good ? 0 : (st_bad ? 1 : (st_ignored ? 2 : 3));
      cap_src  = st_src;
      cap_len  = st_len;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_of(input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c = c ^ frm[i];
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic send_bit(input logic b, input bit gaps);
    if (gaps) repeat ($urandom % 3) @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gaps);
    for (int i = 0; i < 8; i++) send_bit(b[i], gaps);
  endtask

  // stop_after < 0: full frame; otherwise carrier drops after that many bytes
  // poke: offer a bit during the status cycle and keep carrier high
  task automatic run_frame(input logic [7:0] dst, input logic [7:0] src,
                           input int len, input bit corrupt, input int stop_after,
                           input bit poke, input bit gaps, input string tag);
    int n, exp_kind, exp_wr;
    bit acc;
    n = len + 4;
    frm[0] = dst; frm[1] = src; frm[2] = 8'(len);
    for (int i = 0; i < len; i++) frm[3 + i] = 8'($urandom);
    frm[n-1] = crc_of(n - 1) ^ (corrupt ? 8'h01 << ($urandom % 8) : 8'h00);
    wr_cnt = 0; st_cnt = 0; cap_kind = 9;
    acc = (dst == OWN) || (dst == 8'hFF);
    carrier = 1'b1;
    if (stop_after >= 0) begin
      for (int i = 0; i < stop_after; i++) send_byte(frm[i], gaps);
      send_bit(1'b1, gaps);
      carrier = 1'b0;
      repeat (3) @(negedge clk);
      exp_kind = 1;
      exp_wr = acc ? ((stop_after - 3 < 0) ? 0 : stop_after - 3) : 0;
    end else begin
      for (int i = 0; i < n; i++) send_byte(frm[i], gaps);
      // R8: status visible and ready low right after the check byte
      chk(st_valid === 1'b1, {tag, " R8 strobe after check byte"}, st_valid, 1);
      chk(bit_ready === 1'b0, {tag, " R8 ready low during strobe"}, bit_ready, 0);
      if (poke) begin
        bit_valid = 1'b1; bit_data = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        @(negedge clk);
      end else begin
        repeat (2) @(negedge clk);
        carrier = 1'b0;
        @(negedge clk);
      end
      exp_kind = !acc ? 2 : (corrupt ? 1 : 0);
      exp_wr = acc ? len : 0;
      chk(cap_src == src, {tag, " R3 source"}, cap_src, src);
      chk(cap_len == 8'(len), {tag, " R3 length"}, cap_len, len);
    end
    chk(st_cnt == 1, {tag, " R8 one strobe"}, st_cnt, 1);
    chk(cap_kind == exp_kind, {tag, " R5 R6 R7 outcome"}, cap_kind, exp_kind);
    chk(wr_cnt == exp_wr, {tag, " R4 R5 R9 write count"}, wr_cnt, exp_wr);
    if (acc && wr_cnt == exp_wr) begin
      for (int i = 0; i < exp_wr; i++) begin
        if (seen[i] !== frm[3 + i]) begin
          chk(1'b0, {tag, " R2 R4 payload byte"}, seen[i], frm[3 + i]);
          break;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; carrier = 1'b0; bit_valid = 1'b0; bit_data = 1'b0;
    station_addr = OWN;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(st_valid === 1'b0, "R1 st_valid", st_valid, 0);
    chk(buf_we_n === 1'b1, "R1 buf_we_n", buf_we_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_ready === 1'b1, "R1 bit_ready", bit_ready, 1);

    run_frame(OWN, 8'h11, 6, 0, -1, 0, 0, "own");
    run_frame(8'hFF, 8'h22, 5, 0, -1, 0, 1, "bcast");
    run_frame(8'h3C, 8'h33, 7, 0, -1, 0, 0, "other");
    run_frame(OWN, 8'h44, 4, 1, -1, 0, 0, "corrupt");
    run_frame(OWN, 8'h55, 0, 0, -1, 0, 0, "R9 len0");
    run_frame(OWN, 8'h66, 255, 0, -1, 0, 0, "len255");
    run_frame(OWN, 8'h77, 10, 0, 6, 0, 0, "R7 drop");
    run_frame(OWN, 8'h78, 10, 0, 1, 0, 0, "R7 early drop");
    // R8: bit offered during strobe is not consumed; next frame aligned
    run_frame(OWN, 8'h88, 3, 0, -1, 1, 0, "R8 poke");
    run_frame(OWN, 8'h99, 3, 0, -1, 0, 0, "R8 after poke");
    // R2: bits while carrier low are ignored
    carrier = 1'b0;
    for (int i = 0; i < 11; i++) send_bit(1'b1, 0);
    run_frame(OWN, 8'hAA, 2, 0, -1, 0, 0, "R2 after idle bits");

    for (int k = 0; k < 24; k++) begin
      int sel;
      logic [7:0] d;
      sel = $urandom % 3;
      d = (sel == 0) ? OWN : ((sel == 1) ? 8'hFF : 8'(OWN + 1 + ($urandom % 100)));
      run_frame(d, 8'($urandom), $urandom % 40, ($urandom % 4) == 0, -1, 0, 1, "rand");
    end
    summary();
  end
endmodule